// File: doc/BRIEF.md
# Register-Pointer I2C Target

This block is the target side of a two-wire serial bus. It answers one fixed 7-bit device address and gives a master access to a small bank of byte registers. SCL and SDA are oversampled with the system clock. Each line passes through a synchronizer and a short glitch filter. The filtered lines are then decoded into START, STOP, repeated START and the SCL edges that move bits in and out.

In a write transaction, the first data byte after the address selects a register through an internal pointer. Each later byte is stored at the pointer, and the pointer then advances. A read transaction shifts out registers starting at the pointer. The pointer keeps its value across a repeated START. A master can therefore write only the pointer, issue a repeated START with the read bit set, and receive the selected register. The block never drives SDA high. It has one pull-low enable, and that enable combines with the external pull-up to form the open-drain bus.

Top module: `i2c_ptr_target`

## Requirements
- R1: A START is an SDA fall while SCL is high, on the filtered lines. A STOP is an SDA rise while SCL is high. A START clears the bit counter and begins address reception. A STOP returns the block to idle. A repeated START restarts address reception from any state.
- R2: Received bits are sampled on the SCL rising edge, eight per byte, with the most significant bit first. Bit 0 of the address byte is the read flag, where 1 means read.
- R3: When bits 7..1 of the address byte equal DEV_ADDR, the block holds SDA low for the ninth clock. On a mismatch it never pulls SDA low, and it ignores all bytes until the next START, so no register changes.
- R4: In a write transaction, the first data byte loads the pointer from its low log2(NUM_REGS) bits and is acknowledged. Every later byte is stored at the pointer and is acknowledged.
- R5: In a read transaction, the block presents the register at the pointer, MSB first. A 1 bit releases SDA and a 0 bit pulls it low. The pull-low enable changes only while SCL is low.
- R6: The block releases SDA for the ninth clock of each read byte. If the master pulls SDA low in that clock (ACK), the next register follows. If SDA is high (NACK), the block stops driving until the next START or STOP.
- R7: The pointer advances by one after each stored byte and after each byte loaded for reading. It wraps from NUM_REGS-1 to 0.
- R8: The pointer value survives a repeated START and a STOP. A read issued without a pointer byte continues from the current pointer.
- R9: A pulse on SCL or SDA that lasts one system clock is ignored. Such a pulse creates no START or STOP and does not alter a bit.
- R10: sda_oe_o = 1 means SDA is pulled low. After reset, sda_oe_o is 0 and every register reads 0x00. The enable is deasserted in the cycle after a STOP is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | Pull-low enable for SDA; 1 drives the line to 0 |

## Verification
The hardest situation to reach from the ports is a pointer that must persist across a repeated START. This requires a write that stops after the pointer byte and then switches direction without a STOP. The bench builds that sequence both directed and at random pointers, and it mixes in multi-byte runs that cross the end of the register bank. A single-clock SDA pulse placed inside a high SCL phase of a data bit checks that the filter prevents a false START and STOP. The transaction must then complete with the intended byte.

// File: rtl/i2c_ptr_target_pkg.sv
package i2c_ptr_target_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= 1'b1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= sync_q[SYNC_STAGES-1];
      // accept only a level seen on two consecutive samples
      if (sync_q[SYNC_STAGES-1] == hist_q) line_o <= hist_q;
    end
  end

  assert_filt_two_samples_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> ($past(hist_q) == line_o));
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int NUM_REGS = 8,
  parameter int DW       = 8,
  localparam int PW      = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        mem_q[g] <= '0;
      else if (we_i && waddr_i == PW'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_ptr_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int NUM_REGS         = 8,
  parameter int SYNC_STAGES      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int PW = $clog2(NUM_REGS);

  logic [1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic start_det, stop_det, scl_rise, scl_fall;

  assign raw_lines = {scl_i, sda_i};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_tgt_filt #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end
  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2c_tgt_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  tgt_state_e    state_q;
  logic [3:0]    bitcnt_q;
  logic [7:0]    shreg_q;
  logic [PW-1:0] ptr_q;
  logic          rw_q, first_q, mack_q;
  logic          byte_done, ptr_load, reg_we;
  logic [7:0]    rd_data;

  assign byte_done = scl_fall && (bitcnt_q == 4'd8) && !start_det && !stop_det;
  assign ptr_load  = byte_done && (state_q == ST_WR) && first_q;
  assign reg_we    = byte_done && (state_q == ST_WR) && !first_q;

  i2c_tgt_regs #(.NUM_REGS(NUM_REGS), .DW(8)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .waddr_i(ptr_q),
    .wdata_i(shreg_q),
    .raddr_i(ptr_q),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      first_q  <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      first_q  <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            shreg_q  <= {shreg_q[6:0], sda_f};
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (shreg_q[7:1] == DEV_ADDR) begin
                rw_q     <= shreg_q[0];
                sda_oe_o <= 1'b1;
                state_q  <= ST_ADDR_ACK;
              end else begin
                state_q  <= ST_IDLE;
              end
            end else begin
              if (first_q) begin
                ptr_q   <= shreg_q[PW-1:0];
                first_q <= 1'b0;
              end else begin
                ptr_q   <= ptr_q + 1'b1;
              end
              sda_oe_o <= 1'b1;
              state_q  <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt_q <= '0;
            if (!rw_q) begin
              sda_oe_o <= 1'b0;
              first_q  <= 1'b1;
              state_q  <= ST_WR;
            end else begin
              shreg_q  <= rd_data;
              ptr_q    <= ptr_q + 1'b1;
              sda_oe_o <= ~rd_data[7];
              state_q  <= ST_RD;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe_o <= 1'b0;
            bitcnt_q <= '0;
            state_q  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bitcnt_q <= bitcnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RD_ACK;
            end else if (bitcnt_q != 4'd0) begin
              shreg_q  <= {shreg_q[6:0], 1'b0};
              sda_oe_o <= ~shreg_q[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_f;
          end else if (scl_fall) begin
            bitcnt_q <= '0;
            if (mack_q) begin
              shreg_q  <= rd_data;
              ptr_q    <= ptr_q + 1'b1;
              sda_oe_o <= ~rd_data[7];
              state_q  <= ST_RD;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        default: begin
          sda_oe_o <= 1'b0;
        end
      endcase
    end
  end

  assert_start_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (bitcnt_q == 4'd0 && state_q == ST_ADDR));
  assert_bitcnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bitcnt_q <= 4'd8);
  assert_ack_on_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) && $past(state_q) == ST_ADDR) |-> ($past(shreg_q[7:1]) == DEV_ADDR));
  assert_drive_scl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_f);
  assert_ptr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q != $past(ptr_q) && !$past(ptr_load)) |-> (ptr_q == $past(ptr_q) + 1'b1));
  assert_stop_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
endmodule

// File: tb/i2c_ptr_target_tb.sv
module i2c_ptr_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int NREGS      = 8;
  localparam logic [6:0] ADDR = 7'h42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic glitch_n = 1'b1;
  logic sda_oe;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;
  int oe_hi_changes = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [NREGS];
  int mptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & glitch_n & ~sda_oe;

  i2c_ptr_target #(.DEV_ADDR(ADDR), .NUM_REGS(NREGS)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe)
  );

  // R5 monitor: enable may only move while SCL is low
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe != prev_oe) oe_hi_changes++;
    prev_oe <= sda_oe;
  end

  function automatic int next_ptr(input int p, input int n);
    return (p + n) % NREGS;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; qwait(Q);
    scl = 1'b1;   qwait(Q);
    sda_m = 1'b0; qwait(Q);
    scl = 1'b0;   qwait(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qwait(Q);
    scl = 1'b1;   qwait(Q);
    sda_m = 1'b1; qwait(2*Q);
  endtask

  task automatic bus_bit(input bit b, input bit glitch, output bit seen);
    sda_m = b;  qwait(Q);
    scl = 1'b1; qwait(Q/2);
    if (glitch) begin
      glitch_n = 1'b0; qwait(1); glitch_n = 1'b1; qwait(Q/2 - 1);
    end else qwait(Q/2);
    seen = sda_line; qwait(Q);
    scl = 1'b0; qwait(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input int glitch_bit, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], (i == glitch_bit), s);
    bus_bit(1'b1, 1'b0, s);
    acked = !s;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, 1'b0, s);
      b[i] = s;
    end
    bus_bit(!give_ack, 1'b0, s);
  endtask

  // write pointer then len data bytes
  task automatic wr_txn(input logic [7:0] p, input int len, input logic [7:0] d [4]);
    bit a;
    bus_start;
    wr_byte({ADDR, 1'b0}, -1, a); chk(a, "R3 addr ack (write)", a, 1);
    wr_byte(p, -1, a);            chk(a, "R4 pointer byte ack", a, 1);
    mptr = p % NREGS;
    for (int i = 0; i < len; i++) begin
      wr_byte(d[i], -1, a); chk(a, "R4 data byte ack", a, 1);
      model[mptr] = d[i];
      mptr = next_ptr(mptr, 1);
    end
    bus_stop;
  endtask

  // optional pointer write, repeated START, then len reads
  task automatic rd_txn(input bit set_ptr, input logic [7:0] p, input int len);
    bit a;
    logic [7:0] got;
    bus_start;
    if (set_ptr) begin
      wr_byte({ADDR, 1'b0}, -1, a); chk(a, "R3 addr ack (ptr)", a, 1);
      wr_byte(p, -1, a);            chk(a, "R4 pointer ack", a, 1);
      mptr = p % NREGS;
      bus_start;
    end
    wr_byte({ADDR, 1'b1}, -1, a); chk(a, "R3 addr ack (read)", a, 1);
    for (int i = 0; i < len; i++) begin
      rd_byte(i < len - 1, got);
      chk(got == model[mptr], "R5/R7/R8 read data", got, model[mptr]);
      mptr = next_ptr(mptr, 1);
    end
    qwait(Q);
    chk(sda_oe == 1'b0, "R6 released after NACK", sda_oe, 0);
    bus_stop;
  endtask

  initial begin
    repeat (200000 - 100) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d [4];
    bit a;
    logic [7:0] got;
    void'($urandom(32'h1c2d));
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    qwait(5);
    chk(sda_oe == 1'b0, "R10 reset enable", sda_oe, 0);
    rst_n = 1'b1;
    qwait(5);
    chk(sda_oe == 1'b0, "R10 idle enable", sda_oe, 0);

    // R10 reset contents
    rd_txn(1'b1, 8'd0, NREGS);

    // R4 basic write and read back
    d = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
    wr_txn(8'd2, 4, d);
    rd_txn(1'b1, 8'd2, 4);

    // R7 wrap across end of bank
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    wr_txn(8'd6, 4, d);
    rd_txn(1'b1, 8'd7, 3);

    // R8 pointer survives STOP: read without pointer byte
    rd_txn(1'b0, 8'd0, 2);

    // R4 pointer uses low bits only
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    wr_txn(8'hF3, 1, d);
    rd_txn(1'b1, 8'd3, 1);

    // R3 mismatch: no ack, bytes ignored
    bus_start;
    wr_byte({ADDR ^ 7'h01, 1'b0}, -1, a); chk(!a, "R3 mismatch no ack", a, 0);
    wr_byte(8'd3, -1, a);                 chk(!a, "R3 ignored byte no ack", a, 0);
    wr_byte(8'hEE, -1, a);                chk(!a, "R3 ignored data no ack", a, 0);
    bus_stop;
    rd_txn(1'b1, 8'd3, 1);

    // R1 repeated START mid-write restarts address phase
    bus_start;
    wr_byte({ADDR, 1'b0}, -1, a); chk(a, "R1 addr ack", a, 1);
    wr_byte(8'd5, -1, a);         chk(a, "R1 ptr ack", a, 1);
    mptr = 5;
    bus_start;
    wr_byte({ADDR, 1'b1}, -1, a); chk(a, "R1 R8 read after restart", a, 1);
    rd_byte(1'b0, got);
    chk(got == model[5], "R8 pointer kept on restart", got, model[5]);
    mptr = next_ptr(mptr, 1);
    bus_stop;

    // R9 single-clock SDA pulse during SCL high of data bits
    bus_start;
    wr_byte({ADDR, 1'b0}, 4, a); chk(a, "R9 addr ack with glitch", a, 1);
    wr_byte(8'd1, -1, a);        chk(a, "R9 ptr ack", a, 1);
    wr_byte(8'hB7, 2, a);        chk(a, "R9 data ack with glitch", a, 1);
    bus_stop;
    model[1] = 8'hB7;
    mptr = 2;
    rd_txn(1'b1, 8'd1, 1);

    // R2 MSB-first single-bit patterns
    for (int i = 0; i < 8; i++) begin
      d = '{8'(1 << i), 8'h00, 8'h00, 8'h00};
      wr_txn(8'(i), 1, d);
    end
    rd_txn(1'b1, 8'd0, 8);

    // random mix
    for (int k = 0; k < 30; k++) begin
      int len;
      logic [7:0] p;
      len = 1 + ($urandom % 4);
      p = 8'($urandom);
      if ($urandom % 2) begin
        for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
        wr_txn(p, len, d);
      end else begin
        rd_txn(($urandom % 3) != 0, p, len);
      end
    end

    chk(oe_hi_changes == 0, "R5 enable moved while SCL high", oe_hi_changes, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule